// File: doc/BRIEF.md
# SPI Serial Memory Command Slave

This block is the serial front end of a 1024-byte nonvolatile memory. It acts as an SPI mode-0 slave. A transaction opens when chip select goes low. An 8-bit command comes first, and address and data bytes follow. All serial fields travel most significant bit first.

The slave oversamples chip select, serial clock and serial input with the system clock. It decodes six commands:

- set the write latch and clear the write latch
- read the status byte and write the status byte
- read the array and write the array

Array writes pass a range protection check. Each accepted write is reported on a one-cycle parallel request port and committed to an internal byte array. The array then stays busy for a fixed number of clocks.

The status byte can be read at any moment, busy or not. An array read streams successive bytes for as long as the master keeps clocking. Raising chip select ends or aborts whatever was in progress.

Top module: `spi_mem_slave`

## Requirements
- R1: Command byte values are 0x06 (set write latch), 0x04 (clear write latch), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). Any other value is ignored for the rest of the transaction: serial out is never enabled and no state changes.
- R2: Serial input is sampled on rising serial clock edges, starting with the first rising edge after chip select falls. Serial output changes only after falling edges. All fields are most significant bit first.
- R3: The status byte is bit 7 busy, bit 6 write latch, bit 5 zero, bits 4:3 a stored spare field, and bits 2:0 the protection code. It is readable at any time, including while busy. It repeats for every further byte clocked in the same transaction.
- R4: Set-latch and clear-latch commands control the write latch. A committed array write clears it. Write status needs the latch: it then loads bits 4:0 from the data byte and clears the latch. Without the latch, write status has no effect.
- R5: Write array is the command, two address bytes and one data byte. Only the low 10 address bits are used. The write commits on the eighth data bit only if the latch is set, the array is idle and the address is unprotected. A commit pulses the request port for one cycle with the address and data. Further bits in that transaction are ignored.
- R6: Protection codes map to ranges as follows: 0 none; 1 0x000-0x0FF; 2 0x100-0x1FF; 3 0x200-0x2FF; 4 0x300-0x3FF; 5 0x000-0x1FF; 6 0x000-0x00F; 7 0x3F0-0x3FF. Writes into a protected range do not commit and leave the latch set.
- R7: Read array is the command and two address bytes (low 10 bits used). The data bytes follow from that address upwards, and the address wraps from 0x3FF to 0x000.
- R8: For a fixed number of clocks after a commit the array is busy. A read array started then returns no data (serial out stays disabled), and a write array started then does not commit.
- R9: Raising chip select aborts the transaction: a partly shifted write commits nothing and the latch is kept. The serial out enable is low whenever chip select is high.
- R10: The serial clock may idle for any time between edges inside a transaction without loss of state or data.
- R11: After reset the status byte reads 0x00 and the serial out enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master, idle low |
| si_i | input | 1 | Serial data from the master |
| so_o | output | 1 | Serial data to the master |
| so_oe_o | output | 1 | Drive enable for the serial out pad; low means high impedance |
| wr_req_o | output | 1 | One-cycle pulse when an array write commits |
| wr_addr_o | output | 10 | Array address of the committed write |
| wr_data_o | output | 8 | Data byte of the committed write |

## Verification
The bench goes after four corner cases, and a faulty design shows each one differently.

- Reads straddling the top of the array: a design without the wrap streams stale or out-of-range bytes instead of address 0x000.
- Transactions cut short by chip select mid-byte: a design that commits early writes the partial byte or drops the latch.
- Commands issued while the array is busy: a faulty design either drives read data or issues a second request pulse.
- Protection boundaries at every code's first and last byte: an off-by-one in the decoding admits or refuses a write there.

Serial clock pauses mid-byte, extra bytes after a write, and an undefined command are also exercised. Random writes and read-backs are compared against a bench memory model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    // command byte values
    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_ARRAY_WR  = 8'h02;
    localparam logic [7:0] CMD_ARRAY_RD  = 8'h03;

    // bits per serial address field (two bytes)
    localparam int ADDR_FIELD_BITS = 16;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_STWR,
        PH_SINK
    } phase_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_ni,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_s_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic si_s_o
);

    // one extra stage beyond the synchronizer keeps the previous value
    logic [STAGES:0] cs_d, cs_q;
    logic [STAGES:0] sck_d, sck_q;
    logic [STAGES:0] si_d, si_q;

    always_comb begin
        cs_d  = {cs_q[STAGES-1:0], cs_ni};
        sck_d = {sck_q[STAGES-1:0], sck_i};
        si_d  = {si_q[STAGES-1:0], si_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q  <= '1;
            sck_q <= '0;
            si_q  <= '0;
        end else begin
            cs_q  <= cs_d;
            sck_q <= sck_d;
            si_q  <= si_d;
        end
    end

    // deselected as soon as either of the last two samples is high
    assign cs_n_s_o   = cs_q[STAGES-1] | cs_q[STAGES];
    assign sck_rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
    assign si_s_o     = si_q[STAGES];

endmodule

// File: rtl/spi_mem_protect.sv
module spi_mem_protect #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic [2:0]             code_i,
    input  logic [ADDR_W-1:PAGE_W] page_i,
    output logic                   locked_o
);

    logic [1:0] quarter;
    assign quarter = page_i[ADDR_W-1 -: 2];

    always_comb begin
        unique case (code_i)
            3'd1:    locked_o = (quarter == 2'd0);
            3'd2:    locked_o = (quarter == 2'd1);
            3'd3:    locked_o = (quarter == 2'd2);
            3'd4:    locked_o = (quarter == 2'd3);
            3'd5:    locked_o = ~page_i[ADDR_W-1];
            3'd6:    locked_o = (page_i == '0);
            3'd7:    locked_o = &page_i;
            default: locked_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W      = 10,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    generate
        if (BUSY_CYCLES > 0) begin : g_timer
            localparam int CW = $clog2(BUSY_CYCLES + 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (wr_en_i)             cnt_d = CW'(BUSY_CYCLES);
                else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign busy_o = (cnt_q != '0);

            // R8: a commit is always followed by a busy period
            a_r8_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_en_i |=> busy_o);
        end else begin : g_no_timer
            assign busy_o = 1'b0;
        end
    endgenerate

    // R8: the front end never commits into a busy array
    a_r8_no_write_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |-> !busy_o);

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    localparam int CNT_W = $clog2(ADDR_FIELD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_FIELD_BITS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [6:0]        byte_sh;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx;
        logic              oe;
        logic              load;
        logic              wel;
        logic [2:0]        lock;
        logic [1:0]        spare;
        logic              wr_req;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
    } state_t;

    state_t d, q;

    logic       cs_n_s, sck_rise, sck_fall, si_s;
    logic       locked, busy;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic [7:0] full_byte;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cs_ni      (cs_ni),
        .sck_i      (sck_i),
        .si_i       (si_i),
        .cs_n_s_o   (cs_n_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .si_s_o     (si_s)
    );

    spi_mem_protect #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) protect_i (
        .code_i   (q.lock),
        .page_i   (q.addr[ADDR_W-1:PAGE_W]),
        .locked_o (locked)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) array_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (q.wr_req),
        .wr_addr_i (q.wr_addr),
        .wr_data_i (q.wr_data),
        .rd_addr_i (q.addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

    assign status    = {busy, q.wel, 1'b0, q.spare, q.lock};
    assign full_byte = {q.byte_sh, si_s};

    always_comb begin
        d        = q;
        d.wr_req = 1'b0;

        if (cs_n_s) begin
            // deselected: drop the transaction, keep latch and status
            d.phase = PH_CMD;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.load  = 1'b0;
        end else begin
            if (sck_rise) begin
                d.byte_sh = full_byte[6:0];
                d.cnt     = q.cnt + CNT_W'(1);
                unique case (q.phase)
                    PH_CMD: begin
                        if (q.cnt == LAST_BYTE_BIT) begin
                            d.cnt   = '0;
                            d.phase = PH_SINK;
                            unique case (full_byte)
                                CMD_LATCH_SET: d.wel = 1'b1;
                                CMD_LATCH_CLR: d.wel = 1'b0;
                                CMD_STAT_RD: begin
                                    d.phase = PH_STAT;
                                    d.load  = 1'b1;
                                end
                                CMD_STAT_WR:  d.phase = PH_STWR;
                                CMD_ARRAY_WR: begin
                                    d.phase = PH_ADDR;
                                    d.is_wr = 1'b1;
                                end
                                CMD_ARRAY_RD: begin
                                    d.phase = PH_ADDR;
                                    d.is_wr = 1'b0;
                                end
                                default: d.phase = PH_SINK;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        // upper address bits fall off the top of the register
                        d.addr = {q.addr[ADDR_W-2:0], si_s};
                        if (q.cnt == LAST_ADDR_BIT) begin
                            d.cnt = '0;
                            if (q.is_wr) begin
                                d.phase = PH_WDATA;
                            end else if (busy) begin
                                d.phase = PH_SINK;
                            end else begin
                                d.phase = PH_RDATA;
                                d.load  = 1'b1;
                            end
                        end
                    end
                    PH_WDATA: begin
                        if (q.cnt == LAST_BYTE_BIT) begin
                            d.cnt   = '0;
                            d.phase = PH_SINK;
                            if (q.wel && !busy && !locked) begin
                                d.wr_req  = 1'b1;
                                d.wr_addr = q.addr;
                                d.wr_data = full_byte;
                                d.wel     = 1'b0;
                            end
                        end
                    end
                    PH_STWR: begin
                        if (q.cnt == LAST_BYTE_BIT) begin
                            d.cnt   = '0;
                            d.phase = PH_SINK;
                            if (q.wel) begin
                                d.lock  = full_byte[2:0];
                                d.spare = full_byte[4:3];
                                d.wel   = 1'b0;
                            end
                        end
                    end
                    PH_RDATA: begin
                        if (q.cnt == LAST_BYTE_BIT) begin
                            d.cnt  = '0;
                            d.addr = q.addr + ADDR_W'(1);
                            d.load = 1'b1;
                        end
                    end
                    PH_STAT: begin
                        if (q.cnt == LAST_BYTE_BIT) begin
                            d.cnt  = '0;
                            d.load = 1'b1;
                        end
                    end
                    default: d.cnt = '0;
                endcase
            end

            if (sck_fall) begin
                if (q.load) begin
                    d.load = 1'b0;
                    d.oe   = 1'b1;
                    d.tx   = (q.phase == PH_STAT) ? status : rd_data;
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{phase: PH_CMD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign so_o      = q.tx[7];
    assign so_oe_o   = q.oe;
    assign wr_req_o  = q.wr_req;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;

    logic wel_q;
    assign wel_q = q.wel;

    // R9: serial out released one cycle after deselect is seen
    a_r9_so_released_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_s |=> !so_oe_o);

    // R4: a commit consumes a latch that was set
    a_r4_write_consumes_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> ($past(wel_q) && !wel_q));

    // R2: serial out moves only after a falling clock edge
    a_r2_so_moves_on_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_s && !sck_fall) |=> $stable(so_o));

endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BUSY       = 1200;
    localparam int WAIT_IDLE  = BUSY + 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       so, so_oe, wr_req;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;

    spi_mem_slave #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cs_ni     (cs_n),
        .sck_i     (sck),
        .si_i      (si),
        .so_o      (so),
        .so_oe_o   (so_oe),
        .wr_req_o  (wr_req),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         checks = 0;
    int         errors = 0;
    int         wr_cnt = 0;
    bit         done = 1'b0;
    logic [9:0] wr_last_a = '0;
    logic [7:0] wr_last_d = '0;
    logic [7:0] mdl [1024];
    logic [7:0] rb [4];
    bit         rdrv;

    always @(negedge clk) begin
        if (wr_req) begin
            wr_cnt++;
            wr_last_a = wr_addr;
            wr_last_d = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit lk(input logic [2:0] c, input logic [9:0] a);
        case (c)
            3'd1: return a <= 10'h0FF;
            3'd2: return a >= 10'h100 && a <= 10'h1FF;
            3'd3: return a >= 10'h200 && a <= 10'h2FF;
            3'd4: return a >= 10'h300;
            3'd5: return a <= 10'h1FF;
            3'd6: return a <= 10'h00F;
            3'd7: return a >= 10'h3F0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic xbyte(input logic [7:0] b, input int pause_after,
                         output logic [7:0] r, output bit drv);
        drv = 1'b1;
        r   = '0;
        for (int i = 7; i >= 0; i--) begin
            si = b[i];
            tick(HALF);
            r[i] = so;
            if (!so_oe) drv = 1'b0;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
            if (i == pause_after) tick(150);
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        bit d;
        xbyte(b, -1, r, d);
    endtask

    task automatic op1(input logic [7:0] op);
        sel();
        send(op);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        bit d;
        sel();
        send(8'h05);
        xbyte(8'h00, -1, s, d);
        desel();
    endtask

    task automatic wrsr(input logic [7:0] b);
        sel();
        send(8'h01);
        send(b);
        desel();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] dt);
        sel();
        send(8'h02);
        send(a[15:8]);
        send(a[7:0]);
        send(dt);
        desel();
    endtask

    task automatic rd(input logic [15:0] a, input int n, input int pause_at);
        bit d;
        rdrv = 1'b1;
        sel();
        send(8'h03);
        send(a[15:8]);
        send(a[7:0]);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, (k == 0) ? pause_at : -1, rb[k], d);
            rdrv &= d;
        end
        desel();
    endtask

    initial begin
        int watch = 0;
        while (!done && watch < 190000) begin
            @(posedge clk);
            watch++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", watch, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        int         base;
        logic [9:0] bnd [12];

        for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
        void'($urandom(32'd1234));
        bnd = '{10'h000, 10'h00F, 10'h010, 10'h0FF, 10'h100, 10'h1FF,
                10'h200, 10'h2FF, 10'h300, 10'h3EF, 10'h3F0, 10'h3FF};

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R11: reset state
        chk("R11 oe after reset", so_oe, 1'b0);
        rdsr(s);
        chk("R11 status after reset", s, 8'h00);

        // R4: latch set and clear
        op1(8'h06);
        rdsr(s);
        chk("R4 latch set", s, 8'h40);
        op1(8'h04);
        rdsr(s);
        chk("R4 latch cleared", s, 8'h00);

        // R5: write without latch does not commit
        base = wr_cnt;
        wr(16'h0010, 8'hA5);
        chk("R5 no commit without latch", wr_cnt - base, 0);

        // R5 and R8: commit, busy status, read and write during busy
        op1(8'h06);
        base = wr_cnt;
        wr(16'h0123, 8'h5A);
        mdl[10'h123] = 8'h5A;
        chk("R5 commit count", wr_cnt - base, 1);
        chk("R5 request address", wr_last_a, 10'h123);
        chk("R5 request data", wr_last_d, 8'h5A);
        rdsr(s);
        chk("R3 status while busy", s, 8'h80);
        rd(16'h0123, 1, -1);
        chk("R8 read while busy not driven", rdrv, 1'b0);
        op1(8'h06);
        base = wr_cnt;
        wr(16'h0124, 8'h77);
        chk("R8 write while busy ignored", wr_cnt - base, 0);
        tick(WAIT_IDLE);
        rdsr(s);
        chk("R4 latch kept after ignored write", s, 8'h40);
        op1(8'h04);
        rd(16'h0123, 1, -1);
        chk("R2 readback drives", rdrv, 1'b1);
        chk("R2 readback data", rb[0], 8'h5A);
        rd(16'h0124, 1, -1);
        chk("R8 busy write left array", rb[0], 8'h00);

        // R5: upper address bits ignored
        op1(8'h06);
        wr(16'hFC05, 8'h3C);
        mdl[10'h005] = 8'h3C;
        chk("R5 low address bits only", wr_last_a, 10'h005);
        tick(WAIT_IDLE);
        rd(16'h0005, 1, -1);
        chk("R5 upper bits ignored data", rb[0], 8'h3C);

        // R5: extra bytes after data are ignored
        op1(8'h06);
        base = wr_cnt;
        sel();
        send(8'h02); send(8'h00); send(8'h30); send(8'hAA); send(8'hBB);
        desel();
        mdl[10'h030] = 8'hAA;
        chk("R5 one commit with trailing byte", wr_cnt - base, 1);
        tick(WAIT_IDLE);
        rd(16'h0030, 2, -1);
        chk("R5 first byte kept", rb[0], 8'hAA);
        chk("R5 trailing byte not stored", rb[1], mdl[10'h031]);

        // R7: sequential read wraps at the top
        op1(8'h06); wr(16'h03FF, 8'hE1); mdl[10'h3FF] = 8'hE1; tick(WAIT_IDLE);
        op1(8'h06); wr(16'h0000, 8'h1E); mdl[10'h000] = 8'h1E; tick(WAIT_IDLE);
        rd(16'h03FF, 3, -1);
        chk("R7 top byte", rb[0], 8'hE1);
        chk("R7 wrapped byte", rb[1], 8'h1E);
        chk("R7 next byte", rb[2], mdl[10'h001]);

        // R10: clock pause inside a data byte
        rd(16'h0123, 1, 4);
        chk("R10 paused read", rb[0], 8'h5A);

        // R9: aborted write
        op1(8'h06);
        base = wr_cnt;
        sel();
        send(8'h02); send(8'h00); send(8'h40);
        for (int i = 0; i < 4; i++) begin
            si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
        end
        desel();
        chk("R9 no commit on abort", wr_cnt - base, 0);
        rdsr(s);
        chk("R9 latch kept on abort", s, 8'h40);
        op1(8'h04);

        // R9: aborted read releases serial out
        sel();
        send(8'h03); send(8'h01); send(8'h23);
        for (int i = 0; i < 3; i++) begin
            tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
        chk("R9 oe low while deselected", so_oe, 1'b0);
        tick(2 * HALF);

        // R1: undefined command
        begin
            logic [7:0] r;
            bit d;
            sel();
            send(8'h9F);
            xbyte(8'h00, -1, r, d);
            desel();
            chk("R1 undefined command not driven", d, 1'b0);
        end
        rdsr(s);
        chk("R1 status untouched", s, 8'h00);

        // R3: status repeats within a transaction
        op1(8'h06);
        begin
            logic [7:0] r;
            bit d;
            sel();
            send(8'h05);
            for (int k = 0; k < 3; k++) begin
                xbyte(8'h00, -1, r, d);
                chk("R3 repeated status", r, 8'h40);
            end
            desel();
        end
        op1(8'h04);

        // R4: status write without latch ignored
        wrsr(8'h1F);
        rdsr(s);
        chk("R4 status write without latch", s, 8'h00);

        // random writes and reads
        for (int n = 0; n < 20; n++) begin
            logic [15:0] a;
            logic [7:0]  v;
            a = 16'($urandom);
            v = 8'($urandom);
            op1(8'h06);
            wr(a, v);
            mdl[a[9:0]] = v;
            chk("R5 random request address", wr_last_a, a[9:0]);
            tick(WAIT_IDLE);
            rd(a, 2, -1);
            chk("R2 random readback", rb[0], v);
            chk("R7 random next byte", rb[1], mdl[a[9:0] + 10'd1]);
        end

        // R6: protection codes at range edges
        for (int c = 1; c < 8; c++) begin
            logic [1:0] sp;
            sp = 2'($urandom);
            op1(8'h06);
            wrsr({3'b000, sp, 3'(c)});
            rdsr(s);
            chk("R4 status write loads code", s, {3'b000, sp, 3'(c)});
            for (int t = 0; t < 4; t++) begin
                logic [9:0] a;
                logic [7:0] v;
                bit         exp_lock;
                a = bnd[$urandom % 12];
                v = 8'($urandom);
                exp_lock = lk(3'(c), a);
                op1(8'h06);
                base = wr_cnt;
                wr({6'b0, a}, v);
                chk("R6 commit versus range", wr_cnt - base, exp_lock ? 0 : 1);
                if (exp_lock) begin
                    rdsr(s);
                    chk("R6 latch kept on refusal", s[6], 1'b1);
                    op1(8'h04);
                end else begin
                    mdl[a] = v;
                    tick(WAIT_IDLE);
                end
                rd({6'b0, a}, 1, -1);
                chk("R6 array content", rb[0], mdl[a]);
            end
        end
        op1(8'h06);
        wrsr(8'h00);
        rdsr(s);
        chk("R6 protection removed", s, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule